// File: doc/BRIEF.md
# Pipelined Reciprocal-Iteration Unsigned Divider

This block divides one unsigned integer by another and returns the floor quotient, the remainder and a flag for a zero divisor. It takes a new operand pair on any clock cycle and returns one result per cycle after a fixed number of cycles. It suits datapaths that need steady division throughput rather than the shortest latency.

The divisor is first normalised. A leading-zero count shifts its top set bit into the most significant position, and the shift count travels with the operation. The bits just below that leading one address a 16-entry table, which gives a reciprocal seed good to about four bits. Newton-Raphson stages of the form x' = x·(2 − d·x) then refine the seed. Each stage doubles the precision and is built only as wide as the precision it produces, with a few guard bits. The refined reciprocal is multiplied by the dividend and shifted back by the stored count. A final step computes the remainder and corrects the quotient estimate by one in either direction.

Top module: `nrdiv_top`

## Requirements
- R1: For a nonzero divisor, `out_quotient` equals floor(dividend / divisor), for every pair of W-bit unsigned operands.
- R2: For a nonzero divisor, `out_remainder` equals dividend − quotient·divisor, which always lies in [0, divisor).
- R3: A zero divisor drives `out_div_zero` high, `out_quotient` to all ones and `out_remainder` to the dividend. For any nonzero divisor, `out_div_zero` is low.
- R4: Each accepted pair (`in_valid` high at a rising edge) produces `out_valid` high exactly LAT rising edges later, and `out_valid` is low in every other cycle. LAT = 5 + 2·N, where N is the number of precision doublings from SEED_BITS to W. The default is N = 2, which gives LAT = 9.
- R5: Pairs accepted on consecutive cycles come out on consecutive cycles in the same order, with no idle cycle between them.
- R6: While `rst` is high at a rising edge, every valid bit in the pipeline clears. `out_valid` is low on the next cycle, and no pair accepted before the reset ever appears at the outputs.
- R7: The boundary operands are exact. These are a zero dividend, a divisor of one with the largest dividend, equal operands, a dividend smaller than the divisor, power-of-two divisors and the largest divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand pair present this cycle |
| in_dividend | input | W | Unsigned dividend |
| in_divisor | input | W | Unsigned divisor |
| out_valid | output | 1 | Result present this cycle |
| out_quotient | output | W | Floor quotient |
| out_remainder | output | W | Remainder |
| out_div_zero | output | 1 | Divisor of the matching pair was zero |

## Verification
A reciprocal that is too coarse, or a wrong normalisation shift, shows up as a quotient error larger than one. The single-step correction cannot absorb such an error, so the result comes out wrong in the cycle its own valid rises. This is most visible with large dividends over small or power-of-two divisors. A sideband register that slips relative to the datapath pairs a result with a neighbour's dividend or divisor. Back-to-back streams of distinct operands expose this at once. A broken valid chain shows as a missing or extra `out_valid` exactly LAT cycles after the input.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

  // Number of precision-doubling stages from the seed up to the operand width.
  function automatic int nr_stages(int w, int sb);
    int n;
    n = 0;
    for (int p = sb; p < w; p = p * 2) n++;
    return n;
  endfunction

  // Fractional bits carried by the reciprocal after stage k (k = 0 is the seed).
  function automatic int frac_bits(int k, int w, int sb, int g);
    if (k == 0) return sb + 2;
    if (k == nr_stages(w, sb)) return w + g;
    return (sb << k) + g;
  endfunction

  // Reciprocal of the midpoint of table interval i, rounded, with f0 fraction bits.
  function automatic int seed_value(int i, int sb, int f0);
    int num;
    int den;
    num = 1 << (f0 + sb + 2);
    den = (1 << (sb + 1)) + 2 * i + 1;
    return (2 * num + den) / (2 * den);
  endfunction

  function automatic int pipe_latency(int w, int sb);
    return 5 + 2 * nr_stages(w, sb);
  endfunction

endpackage

// File: rtl/nrdiv_norm.sv
module nrdiv_norm #(
  parameter int W   = 16,
  parameter int SW  = 4,
  parameter int SBW = 2 * 16 + 4 + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           i_v,
  input  logic [W-1:0]   i_a,
  input  logic [W-1:0]   i_d,
  output logic           o_v,
  output logic [W-1:0]   o_dn,
  output logic [SBW-1:0] o_sb
);
  logic [SW-1:0] lz;

  // The highest set bit is visited last, so it decides the count.
  always_comb begin
    lz = '0;
    for (int i = 0; i < W; i++)
      if (i_d[i]) lz = SW'(W - 1 - i);
  end

  always_ff @(posedge clk) begin
    if (rst) o_v <= 1'b0;
    else     o_v <= i_v;
  end

  always_ff @(posedge clk) begin
    o_dn <= i_d << lz;
    o_sb <= {i_a, i_d, lz, (i_d == '0)};
  end
endmodule

// File: rtl/nrdiv_seed.sv
module nrdiv_seed #(
  parameter int W   = 16,
  parameter int SB  = 4,
  parameter int F0  = 6,
  parameter int SBW = 37
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           i_v,
  input  logic [W-1:0]   i_dn,
  input  logic [SBW-1:0] i_sb,
  output logic           o_v,
  output logic [F0+1:0]  o_x,
  output logic [W-1:0]   o_dn,
  output logic [SBW-1:0] o_sb
);
  import nrdiv_pkg::*;
  localparam int NE = 1 << SB;

  logic [F0+1:0] rom [NE];
  logic [SB-1:0] idx;

  for (genvar i = 0; i < NE; i++) begin : g_rom
    assign rom[i] = (F0 + 2)'(seed_value(i, SB, F0));
  end

  // Bits just below the leading one select the interval.
  assign idx = i_dn[W-2 -: SB];

  always_ff @(posedge clk) begin
    if (rst) o_v <= 1'b0;
    else     o_v <= i_v;
  end

  always_ff @(posedge clk) begin
    o_x  <= rom[idx];
    o_dn <= i_dn;
    o_sb <= i_sb;
  end
endmodule

// File: rtl/nrdiv_nr_stage.sv
module nrdiv_nr_stage #(
  parameter int W    = 16,
  parameter int FIN  = 6,
  parameter int FOUT = 12,
  parameter int SBW  = 37
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            i_v,
  input  logic [FIN+1:0]  i_x,
  input  logic [W-1:0]    i_dn,
  input  logic [SBW-1:0]  i_sb,
  output logic            o_v,
  output logic [FOUT+1:0] o_x,
  output logic [W-1:0]    o_dn,
  output logic [SBW-1:0]  o_sb
);
  localparam int PW1 = FOUT + FIN + 2;
  localparam int PW2 = FIN + FOUT + 4;

  logic [FOUT-1:0] dt;

  // Divisor fraction cut or padded to the precision this stage delivers.
  if (FOUT <= W) begin : g_trunc
    assign dt = i_dn[W-1 -: FOUT];
  end else begin : g_ext
    assign dt = {i_dn, {(FOUT - W){1'b0}}};
  end

  logic [PW1-1:0]  p1;
  logic [FOUT+1:0] t, e;
  assign p1 = PW1'(dt) * PW1'(i_x);
  assign t  = p1[FIN +: FOUT + 2];
  assign e  = {2'b10, {FOUT{1'b0}}} - t;

  logic            v1;
  logic [FIN+1:0]  x1;
  logic [FOUT+1:0] e1;
  logic [W-1:0]    dn1;
  logic [SBW-1:0]  sb1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1  <= 1'b0;
      o_v <= 1'b0;
    end else begin
      v1  <= i_v;
      o_v <= v1;
    end
  end

  logic [PW2-1:0] p2;
  assign p2 = PW2'(x1) * PW2'(e1);

  always_ff @(posedge clk) begin
    x1   <= i_x;
    e1   <= e;
    dn1  <= i_dn;
    sb1  <= i_sb;
    o_x  <= p2[FIN +: FOUT + 2];
    o_dn <= dn1;
    o_sb <= sb1;
  end
endmodule

// File: rtl/nrdiv_fix.sv
module nrdiv_fix #(
  parameter int W   = 16,
  parameter int SW  = 4,
  parameter int XF  = 20,
  parameter int SBW = 37
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           i_v,
  input  logic [XF+1:0]  i_x,
  input  logic [SBW-1:0] i_sb,
  output logic           o_v,
  output logic [W-1:0]   o_q,
  output logic [W-1:0]   o_r,
  output logic           o_z
);
  localparam int PW   = XF + 2 + W;
  localparam int BASE = XF + W;

  logic [W-1:0]  a0, d0;
  logic [SW-1:0] s0;
  assign a0 = i_sb[SBW-1 -: W];
  assign d0 = i_sb[SBW-1-W -: W];
  assign s0 = i_sb[SW:1];

  logic [PW-1:0] prod, qsh;
  assign prod = PW'(i_x) * PW'(a0);
  assign qsh  = prod >> (BASE - int'(s0));

  // Step 1: quotient estimate.
  logic           v1;
  logic [W:0]     q1;
  logic [SBW-1:0] sb1;

  // Step 2: signed remainder of the estimate.
  logic                  v2;
  logic [W:0]            q2;
  logic signed [W+1:0]   r2;
  logic [W-1:0]          a2, d2;
  logic                  z2;

  logic [W-1:0]   a1, d1;
  logic [2*W:0]   qd;
  assign a1 = sb1[SBW-1 -: W];
  assign d1 = sb1[SBW-1-W -: W];
  assign qd = (2 * W + 1)'(q1) * (2 * W + 1)'(d1);

  logic signed [W+1:0] dxs;
  assign dxs = signed'({2'b00, d2});

  always_ff @(posedge clk) begin
    if (rst) begin
      v1  <= 1'b0;
      v2  <= 1'b0;
      o_v <= 1'b0;
    end else begin
      v1  <= i_v;
      v2  <= v1;
      o_v <= v2;
    end
  end

  always_ff @(posedge clk) begin
    q1  <= qsh[W:0];
    sb1 <= i_sb;
    q2  <= q1;
    r2  <= signed'({2'b00, a1} - qd[W+1:0]);
    a2  <= a1;
    d2  <= d1;
    z2  <= sb1[0];
    o_z <= z2;
    if (z2) begin
      o_q <= '1;
      o_r <= a2;
    end else if (r2 < 0) begin
      o_q <= W'(q2 - 1'b1);
      o_r <= W'(r2 + dxs);
    end else if (r2 >= dxs) begin
      o_q <= W'(q2 + 1'b1);
      o_r <= W'(r2 - dxs);
    end else begin
      o_q <= W'(q2);
      o_r <= W'(r2);
    end
  end
endmodule

// File: rtl/nrdiv_top.sv
module nrdiv_top #(
  parameter int W         = 16,
  parameter int SEED_BITS = 4,
  parameter int GUARD     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_dividend,
  input  logic [W-1:0] in_divisor,
  output logic         out_valid,
  output logic [W-1:0] out_quotient,
  output logic [W-1:0] out_remainder,
  output logic         out_div_zero
);
  import nrdiv_pkg::*;

  localparam int NST = nr_stages(W, SEED_BITS);
  localparam int SW  = $clog2(W);
  localparam int SBW = 2 * W + SW + 1;
  localparam int F0  = frac_bits(0, W, SEED_BITS, GUARD);
  localparam int XF  = frac_bits(NST, W, SEED_BITS, GUARD);
  localparam int XW  = XF + 2;

  logic           n_v;
  logic [W-1:0]   n_dn;
  logic [SBW-1:0] n_sb;
  logic [F0+1:0]  x0;

  logic           vs  [NST+1];
  logic [XW-1:0]  xs  [NST+1];
  logic [W-1:0]   dns [NST+1];
  logic [SBW-1:0] sbs [NST+1];

  nrdiv_norm #(.W(W), .SW(SW), .SBW(SBW)) u_norm (
    .clk(clk), .rst(rst), .i_v(in_valid), .i_a(in_dividend), .i_d(in_divisor),
    .o_v(n_v), .o_dn(n_dn), .o_sb(n_sb)
  );

  nrdiv_seed #(.W(W), .SB(SEED_BITS), .F0(F0), .SBW(SBW)) u_seed (
    .clk(clk), .rst(rst), .i_v(n_v), .i_dn(n_dn), .i_sb(n_sb),
    .o_v(vs[0]), .o_x(x0), .o_dn(dns[0]), .o_sb(sbs[0])
  );
  assign xs[0] = XW'(x0);

  for (genvar k = 0; k < NST; k++) begin : g_iter
    localparam int FIN  = frac_bits(k, W, SEED_BITS, GUARD);
    localparam int FOUT = frac_bits(k + 1, W, SEED_BITS, GUARD);
    logic [FOUT+1:0] xo;
    nrdiv_nr_stage #(.W(W), .FIN(FIN), .FOUT(FOUT), .SBW(SBW)) u_stage (
      .clk(clk), .rst(rst), .i_v(vs[k]), .i_x(xs[k][FIN+1:0]),
      .i_dn(dns[k]), .i_sb(sbs[k]),
      .o_v(vs[k+1]), .o_x(xo), .o_dn(dns[k+1]), .o_sb(sbs[k+1])
    );
    assign xs[k+1] = XW'(xo);
  end

  nrdiv_fix #(.W(W), .SW(SW), .XF(XF), .SBW(SBW)) u_fix (
    .clk(clk), .rst(rst), .i_v(vs[NST]), .i_x(xs[NST]), .i_sb(sbs[NST]),
    .o_v(out_valid), .o_q(out_quotient), .o_r(out_remainder), .o_z(out_div_zero)
  );
endmodule

// File: rtl/nrdiv_check.sv
module nrdiv_check #(
  parameter int W         = 16,
  parameter int SEED_BITS = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_dividend,
  input logic [W-1:0] in_divisor,
  input logic         out_valid,
  input logic [W-1:0] out_quotient,
  input logic [W-1:0] out_remainder,
  input logic         out_div_zero
);
  import nrdiv_pkg::*;
  localparam int LAT = pipe_latency(W, SEED_BITS);

  logic [LAT-1:0] vh;
  logic [W-1:0]   ah [LAT];
  logic [W-1:0]   dh [LAT];

  always_ff @(posedge clk) begin
    if (rst) vh <= '0;
    else     vh <= {vh[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    ah[0] <= in_dividend;
    dh[0] <= in_divisor;
    for (int i = 1; i < LAT; i++) begin
      ah[i] <= ah[i-1];
      dh[i] <= dh[i-1];
    end
  end

  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid == vh[LAT-1]);

  p_exact_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_div_zero) |->
      ((2 * W)'(out_quotient) * (2 * W)'(dh[LAT-1]) + (2 * W)'(out_remainder)
       == (2 * W)'(ah[LAT-1])));

  p_rem_range_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_div_zero) |-> (out_remainder < dh[LAT-1]));

  p_zero_flag_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_div_zero == (dh[LAT-1] == '0)));

  p_zero_result_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_div_zero) |-> ((&out_quotient) && out_remainder == ah[LAT-1]));

  p_reset_clear_r6: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind nrdiv_top nrdiv_check #(.W(W), .SEED_BITS(SEED_BITS)) u_chk (.*);

// File: tb/tb_nrdiv_top.sv
module tb_nrdiv_top;
  localparam int W   = 16;
  localparam int LAT = 9;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_dividend = '0;
  logic [W-1:0] in_divisor = '0;
  logic         out_valid;
  logic [W-1:0] out_quotient, out_remainder;
  logic         out_div_zero;

  nrdiv_top #(.W(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_dividend(in_dividend), .in_divisor(in_divisor),
    .out_valid(out_valid), .out_quotient(out_quotient),
    .out_remainder(out_remainder), .out_div_zero(out_div_zero)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic         hv [LAT];
  logic [W-1:0] ha [LAT];
  logic [W-1:0] hd [LAT];
  string vtag = "R6";
  string qtag = "R1";
  string rtag = "R2";

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: compare outputs against the model, then drive the next inputs.
  task automatic step(bit r, bit v, logic [W-1:0] a, logic [W-1:0] d);
    logic [W-1:0] ea, ed;
    @(negedge clk);
    chk(out_valid === hv[LAT-1], vtag, "out_valid", longint'(out_valid), longint'(hv[LAT-1]));
    if (hv[LAT-1]) begin
      ea = ha[LAT-1];
      ed = hd[LAT-1];
      if (ed == '0) begin
        chk(out_div_zero === 1'b1, "R3", "div_zero", longint'(out_div_zero), 1);
        chk(out_quotient === '1, "R3", "quotient", longint'(out_quotient), longint'({W{1'b1}}));
        chk(out_remainder === ea, "R3", "remainder", longint'(out_remainder), longint'(ea));
      end else begin
        chk(out_div_zero === 1'b0, "R3", "div_zero", longint'(out_div_zero), 0);
        chk(out_quotient === ea / ed, qtag, "quotient", longint'(out_quotient), longint'(ea / ed));
        chk(out_remainder === ea % ed, rtag, "remainder", longint'(out_remainder), longint'(ea % ed));
      end
    end
    for (int i = LAT - 1; i > 0; i--) begin
      hv[i] = hv[i-1];
      ha[i] = ha[i-1];
      hd[i] = hd[i-1];
    end
    hv[0] = v;
    ha[0] = a;
    hd[0] = d;
    if (r) for (int i = 0; i < LAT; i++) hv[i] = 1'b0;
    rst         = r;
    in_valid    = v;
    in_dividend = a;
    in_divisor  = d;
  endtask

  function automatic logic [W-1:0] rand_div();
    logic [W-1:0] d;
    d = W'($urandom) >> ($urandom % W);
    if ($urandom % 16 == 0) d = '0;
    return d;
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < LAT; i++) begin
      hv[i] = 1'b0; ha[i] = '0; hd[i] = '0;
    end
    void'($urandom(32'd2024));

    // R6: reset state, out_valid stays low.
    vtag = "R6";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, '0);
    idle(3);

    // R7 corners and R3 zero divisors, spaced to exercise R4 timing.
    vtag = "R4"; qtag = "R7"; rtag = "R7";
    step(0, 1, 16'd0,     16'd1);
    step(0, 1, 16'hFFFF,  16'd1);     idle(1);
    step(0, 1, 16'hFFFF,  16'hFFFF);
    step(0, 1, 16'd5,     16'd7);     idle(2);
    step(0, 1, 16'h8000,  16'h8000);
    step(0, 1, 16'hFFFF,  16'h8000);
    step(0, 1, 16'h1234,  16'hFFFE);
    step(0, 1, 16'hFFFF,  16'h0002);
    step(0, 1, 16'hFFFE,  16'h0003);
    step(0, 1, 16'd100,   16'd10);
    step(0, 1, 16'd1234,  16'd0);
    step(0, 1, 16'd0,     16'd0);
    step(0, 1, 16'hFFFF,  16'h0101);
    idle(LAT + 1);

    // R5: back-to-back random stream, R1/R2 values.
    vtag = "R5"; qtag = "R1"; rtag = "R2";
    for (int i = 0; i < 400; i++) step(1'b0, 1'b1, W'($urandom), rand_div());
    idle(LAT + 1);

    // R4: sparse random stream.
    vtag = "R4";
    for (int i = 0; i < 400; i++) step(1'b0, 1'($urandom % 2), W'($urandom), rand_div());
    idle(LAT + 1);

    // R6: reset in the middle of a stream discards pairs in flight.
    vtag = "R6";
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, W'($urandom), rand_div());
    step(1'b1, 1'b1, 16'd77, 16'd7);
    idle(LAT + 2);

    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      finish_run();
    end
  end
endmodule